// File: doc/BRIEF.md
# UART Register Block

This block is the processor-facing side of a simple serial port. A word-addressed bus reaches four 32-bit registers: receive data, transmit data, status and control. Incoming bytes enter through a valid/ready byte port and wait in an eight-entry receive queue. Transmit bytes leave on a byte output as a one-cycle strobe. Baud timing and line framing live in a neighbouring block. The overrun, framing and parity status bits are therefore always zero.

Software can poll status or use the level interrupt. A sticky pending flag drives the interrupt. The flag is set while received data waits and on every transmit write. A read of status clears it. The flag reaches `irq_o` only when the control enable bit is set.

Top module: `uart_regif`

## Requirements
- R1: After reset, the receive queue is empty, control holds 0 and the pending flag is 0. `rx_ready_o` is 1, `irq_o` is 0, `tx_valid_o` is 0, and a status read returns 0x04.
- R2: A read with `addr_i[3:2]`=0 (byte offset 0x0) returns the oldest queued byte in bits 7:0 and zero above, and removes that byte. Bytes come out in the order they were accepted.
- R3: The queue holds `RX_DEPTH` (8) bytes. With 8 bytes held, `rx_ready_o` is 0 and an offered byte is dropped.
- R4: A receive-data read while the queue is empty returns 0 and leaves the queue empty.
- R5: If a byte is accepted in the same cycle as a receive-data read of a non-empty queue, the read returns the oldest byte, the new byte is stored, and the byte count is unchanged.
- R6: A control write (offset 0xC) with bit 1 set empties the receive queue. The written word is still stored, and a control read returns it.
- R7: Status (offset 0x8) reads with this layout: bit0 = queue non-empty, bit1 = queue full, bit2 = transmit empty (always 1), bit3 = transmit full (always 0), bit4 = pending. Bits 5 to 7 and all upper bits are 0.
- R8: The pending flag is set by any transmit write. It is also set at the end of every cycle in which the queue is left non-empty, and it stays set until cleared.
- R9: A status read clears the pending flag, unless the queue is non-empty at the end of that cycle; in that case the flag stays set.
- R10: `irq_o` is 1 exactly when the pending flag is set and control bit 4 is set.
- R11: A write to offset 0x4 raises `tx_valid_o` for one cycle in the cycle after the write, with `tx_data_o` equal to the low byte written. A read of offset 0x4 returns the last word written there.
- R12: Writes to status have no effect. An access with any address bit above bit 3 set reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte address; bits 3:2 pick the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational during a read, 0 otherwise |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Queue can take a byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The two functions that can fall in the same cycle are a byte arriving on the receive port and a bus read that pops the receive queue. The bench drives `rx_valid_i` in the very cycle a receive-data read is issued, with two bytes already queued. It judges the result by the byte that read returns and by how many further reads return data before an empty read gives zero. A similar overlap comes from reading status while bytes are still queued. In that case the pending flag, and hence `irq_o`, must stay set.

// File: rtl/uart_regif_pkg.sv
`timescale 1ns/1ps
package uart_regif_pkg;
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int ST_RXVAL   = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXFULL  = 3;
  localparam int ST_PEND    = 4;

  localparam int CT_TXRST = 0;
  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;
endpackage

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [BYTE_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_nxt_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign count_nxt_o = cnt_d;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i)                cnt_d = '0;
    else if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
      end else begin
        if (do_push) wr_ptr_q <= wrap_inc(wr_ptr_q);
        if (do_pop)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[i] <= '0;
      else if (do_push && !flush_i && wr_ptr_q == PTR_W'(i)) mem_q[i] <= data_i;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic level_i,
  input  logic en_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  // clear loses to any set source in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !clr_i) || set_i || level_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && en_i;
endmodule

// File: rtl/uart_tx_port.sv
`timescale 1ns/1ps
module uart_tx_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= wr_i;
      if (wr_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/uart_regif.sv
`timescale 1ns/1ps
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int RX_DEPTH = 8,
  parameter int BYTE_W   = 8,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o
);
  logic              acc, rd, wr;
  reg_sel_e          sel;
  logic              rx_pop, rx_push, tx_wr, ctrl_wr, stat_rd, rx_flush;
  logic [DATA_W-1:0] ctrl_q, tx_word_q, status_w;
  logic [BYTE_W-1:0] head;
  logic [CNT_W-1:0]  rx_count, rx_count_nxt;
  logic              rx_full, rx_empty, pend_q;

  assign acc = req_i && (addr_i[ADDR_W-1:4] == '0);
  assign sel = reg_sel_e'(addr_i[3:2]);
  assign rd  = acc && !we_i;
  assign wr  = acc && we_i;

  assign rx_pop   = rd && (sel == REG_RXD);
  assign stat_rd  = rd && (sel == REG_STAT);
  assign tx_wr    = wr && (sel == REG_TXD);
  assign ctrl_wr  = wr && (sel == REG_CTRL);
  assign rx_flush = ctrl_wr && wdata_i[CT_RXRST];
  assign rx_push  = rx_valid_i && rx_ready_o;
  assign rx_ready_o = !rx_full;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)) u_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_push),
    .data_i      (rx_data_i),
    .pop_i       (rx_pop),
    .flush_i     (rx_flush),
    .head_o      (head),
    .count_o     (rx_count),
    .count_nxt_o (rx_count_nxt),
    .full_o      (rx_full),
    .empty_o     (rx_empty)
  );

  uart_irq_ctrl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (stat_rd),
    .set_i   (tx_wr),
    .level_i (rx_count_nxt != '0),
    .en_i    (ctrl_q[CT_IE]),
    .pend_o  (pend_q),
    .irq_o   (irq_o)
  );

  uart_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (tx_wr),
    .data_i  (wdata_i[BYTE_W-1:0]),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tx_word_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q    <= wdata_i;
      if (tx_wr)   tx_word_q <= wdata_i;
    end
  end

  always_comb begin
    status_w              = '0;
    status_w[ST_RXVAL]    = !rx_empty;
    status_w[ST_RXFULL]   = rx_full;
    status_w[ST_TXEMPTY]  = 1'b1;
    status_w[ST_TXFULL]   = 1'b0;
    status_w[ST_PEND]     = pend_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        REG_RXD:  rdata_o = rx_empty ? '0 : DATA_W'(head);
        REG_TXD:  rdata_o = tx_word_q;
        REG_STAT: rdata_o = status_w;
        REG_CTRL: rdata_o = ctrl_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
`timescale 1ns/1ps
module uart_regif_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_i,
  input logic              pend_i,
  input logic              ie_i
);
  logic hit, c_tx_wr, c_rx_rd, c_flush;
  assign hit     = req_i && (addr_i[ADDR_W-1:4] == '0);
  assign c_tx_wr = hit && we_i && (addr_i[3:2] == 2'd1);
  assign c_rx_rd = hit && !we_i && (addr_i[3:2] == 2'd0);
  assign c_flush = hit && we_i && (addr_i[3:2] == 2'd3) && wdata_i[1];

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  p_full_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CNT_W'(DEPTH)) |-> !rx_ready_o);

  p_push_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && c_rx_rd && !c_flush && count_i != '0)
      |=> (count_i == $past(count_i)));

  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_flush |=> (count_i == '0));

  p_pend_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0) |-> pend_i);

  p_pend_tx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_tx_wr |=> pend_i);

  p_irq_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_tx_wr && ie_i) |=> irq_o);

  p_irq_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !irq_o);

  p_tx_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_tx_wr |=> (tx_valid_o && tx_data_o == $past(wdata_i[BYTE_W-1:0])));

  p_tx_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_tx_wr |=> !tx_valid_o);
endmodule

bind uart_regif uart_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RX_DEPTH), .BYTE_W(BYTE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .irq_o      (irq_o),
  .count_i    (rx_count),
  .pend_i     (pend_q),
  .ie_i       (ctrl_q[4])
);

// File: tb/tb_uart_regif.sv
`timescale 1ns/1ps
module tb_uart_regif;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o, tx_valid_o, irq_o;
  logic [7:0]  tx_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_regif dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .irq_o(irq_o)
  );

  localparam logic [7:0] A_RX = 8'h00, A_TX = 8'h04, A_ST = 8'h08, A_CT = 8'h0C, A_NONE = 8'h10;

  typedef struct packed {
    logic [1:0]  kind;   // 0 read, 1 write, 2 push byte
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, A_ST,   32'h0,     32'h04},   // R1 R7
    '{2'd2, 8'h0,   32'h11,    32'h0},
    '{2'd2, 8'h0,   32'h22,    32'h0},
    '{2'd0, A_ST,   32'h0,     32'h15},   // R7 R8
    '{2'd0, A_RX,   32'h0,     32'h11},   // R2
    '{2'd0, A_RX,   32'h0,     32'h22},   // R2
    '{2'd0, A_RX,   32'h0,     32'h00},   // R4
    '{2'd0, A_ST,   32'h0,     32'h14},   // R8 sticky
    '{2'd0, A_ST,   32'h0,     32'h04},   // R9
    '{2'd1, A_CT,   32'h10,    32'h0},
    '{2'd0, A_CT,   32'h0,     32'h10},   // R6 readback
    '{2'd1, A_ST,   32'hFF,    32'h0},
    '{2'd0, A_ST,   32'h0,     32'h04},   // R12
    '{2'd0, A_NONE, 32'h0,     32'h00},   // R12
    '{2'd1, A_TX,   32'h1A5,   32'h0},
    '{2'd0, A_TX,   32'h0,     32'h1A5},  // R11
    '{2'd0, A_ST,   32'h0,     32'h14},   // R8
    '{2'd0, A_ST,   32'h0,     32'h04}    // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1 req_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = v;
    @(posedge clk_i); #1 req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(posedge clk_i); #1 rx_valid_i = 1'b0;
  endtask

  task automatic push_rd(input logic [7:0] b, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = b;
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1 rx_valid_i = 1'b0; req_i = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 rx_ready", 32'(rx_ready_o), 32'h1);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 tx_valid", 32'(tx_valid_o), 32'h0);
    chk("R1 idle rdata", rdata_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        2'd0: begin
          bus_rd(VECS[i].addr, d);
          chk($sformatf("R2/R4/R6/R7/R8/R9/R11/R12 vec%0d", i), d, VECS[i].exp);
        end
        2'd1: bus_wr(VECS[i].addr, VECS[i].data);
        default: push(VECS[i].data[7:0]);
      endcase
    end

    // R3: fill, full flags, drop while full
    for (int i = 0; i < 8; i++) push(8'h30 + 8'(i));
    bus_rd(A_ST, d); chk("R3 R7 full status", d, 32'h17);
    chk("R3 ready low when full", 32'(rx_ready_o), 32'h0);
    chk("R10 irq with ie and pending", 32'(irq_o), 32'h1);
    push(8'hEE);
    for (int i = 0; i < 8; i++) begin
      bus_rd(A_RX, d); chk("R2 R3 order", d, 32'h30 + 32'(i));
    end
    bus_rd(A_RX, d); chk("R3 R4 dropped byte absent", d, 32'h0);
    bus_rd(A_ST, d); chk("R9 clear on status read", d, 32'h14);
    bus_rd(A_ST, d); chk("R9 cleared", d, 32'h04);

    // R5: push and pop in same cycle
    push(8'h41); push(8'h42);
    push_rd(8'h43, A_RX, d); chk("R5 pop during push", d, 32'h41);
    bus_rd(A_RX, d); chk("R5 second", d, 32'h42);
    bus_rd(A_RX, d); chk("R5 pushed byte kept", d, 32'h43);
    bus_rd(A_RX, d); chk("R5 count unchanged", d, 32'h0);
    bus_rd(A_ST, d); bus_rd(A_ST, d);

    // R9: status read with data queued keeps pending
    push(8'h55);
    bus_rd(A_ST, d); chk("R9 first read nonempty", d, 32'h15);
    bus_rd(A_ST, d); chk("R9 pending kept", d, 32'h15);
    bus_rd(A_RX, d); chk("R2 single byte", d, 32'h55);
    bus_rd(A_ST, d); bus_rd(A_ST, d); chk("R9 cleared after drain", d, 32'h04);

    // R6: flush
    push(8'h61); push(8'h62); push(8'h63);
    bus_wr(A_CT, 32'h12);
    bus_rd(A_ST, d); chk("R6 flushed status", d, 32'h14);
    bus_rd(A_CT, d); chk("R6 ctrl stored", d, 32'h12);
    bus_rd(A_RX, d); chk("R6 empty after flush", d, 32'h0);
    chk("R6 ready after flush", 32'(rx_ready_o), 32'h1);
    bus_rd(A_ST, d);

    // R10 / R11
    bus_wr(A_CT, 32'h00);
    bus_wr(A_TX, 32'hAB77);
    chk("R11 strobe high", 32'(tx_valid_o), 32'h1);
    chk("R11 strobe data", 32'(tx_data_o), 32'h77);
    @(posedge clk_i); #1;
    chk("R11 strobe one cycle", 32'(tx_valid_o), 32'h0);
    chk("R10 masked irq", 32'(irq_o), 32'h0);
    bus_wr(A_CT, 32'h10);
    chk("R10 irq on enable", 32'(irq_o), 32'h1);
    bus_rd(A_ST, d); chk("R8 tx sets pending", d, 32'h14);
    chk("R10 irq drops after clear", 32'(irq_o), 32'h0);
    push(8'h01);
    chk("R10 irq on rx byte", 32'(irq_o), 32'h1);
    bus_rd(A_RX, d);
    chk("R8 sticky after drain", 32'(irq_o), 32'h1);
    bus_rd(A_ST, d);
    chk("R9 irq clear", 32'(irq_o), 32'h0);

    // R12: unmapped write has no effect on ctrl
    bus_wr(8'h1C, 32'h0);
    bus_rd(A_CT, d); chk("R12 unmapped write ignored", d, 32'h10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule